// File: doc/BRIEF.md
# Programmable Square-Wave Generator

The block produces one square-wave output from a reference timebase. A one-cycle enable marks every half period of a 32.768 kHz reference. An 8-bit control byte selects what the output does. With the wave enabled, one of four rates appears on the output: the reference itself, reference/4, reference/8, or a once-per-second wave. With the wave disabled, the output holds a programmable static level.

All rates are taken from one binary divider that advances on the reference enable. The same divider gives a one-cycle update strobe once per second. This strobe tells the timekeeping logic when to advance its counters, and it lands in the same cycle as the falling edge of the once-per-second wave.

A rate or enable change does not take effect at once. The output holds its level until the newly chosen divider tap changes. At that point the switch is made only if it cannot produce a high or low segment shorter than half a period of the new rate.

Top module: `sqw_gen`

## Requirements
- R1: After reset the control byte reads 0x03 (static level 0, wave disabled, rate code 11), `sqw_o` is 0 and `sec_tick_o` is 0.
- R2: A write sets the static level from bit 7, the enable from bit 4 and the rate code from bits 1:0. The other bits are dropped and read back as 0. The new value reads back in the cycle after the write.
- R3: While bit 4 of the control byte is 0, `sqw_o` equals bit 7 from the second clock after the write and does not toggle.
- R4: With one `tick_i` per reference half period, the output's half period in ticks is 1 for rate code 11, 4 for code 10, 8 for code 01 and 2^(DIV_W-1) for code 00. With the default DIV_W=16 these are 32.768 kHz, 8.192 kHz, 4.096 kHz and 1 Hz.
- R5: The divider advances only on cycles with `tick_i` high. While it is low, the enabled output and the strobe do not change.
- R6: `sec_tick_o` is a one-cycle pulse once every 2^DIV_W ticks, in every mode.
- R7: Once the wave is running at rate code 00, `sec_tick_o` is high exactly in the cycles where `sqw_o` falls.
- R8: After the rate or enable changes, no high or low segment of `sqw_o` is shorter than half a period of the new rate. Once the switch has been made, the output runs at exactly the new rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Reference half-period enable |
| ctrl_wr_i | input | 1 | Control byte write strobe |
| ctrl_wdata_i | input | 8 | Control byte write data |
| ctrl_rdata_o | output | 8 | Control byte read-back |
| sqw_o | output | 1 | Square-wave or static-level output |
| sec_tick_o | output | 1 | Once-per-second update strobe |

## Verification
Two events can fall in the same clock edge: the falling edge of the once-per-second wave and the update strobe. Both come from the same divider rollover, so an off-by-one in either path splits them apart by a cycle. The bench selects the slowest rate, waits until the output has locked, then compares the fall of `sqw_o` against `sec_tick_o` on every cycle across several periods. A second point of contact is a rate write landing on the same edge as an output toggle. This is provoked by writing right after a seen edge, and it is judged by the length of the segment that spans the switch.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

  typedef enum logic [1:0] {
    RATE_SEC  = 2'b00,
    RATE_DIV8 = 2'b01,
    RATE_DIV4 = 2'b10,
    RATE_REF  = 2'b11
  } rate_e;

  typedef struct packed {
    logic  lvl;
    logic  en;
    rate_e rate;
  } ctrl_t;

  // divider bit whose level forms the selected wave
  function automatic int unsigned tap_idx(rate_e r, int unsigned div_w);
    case (r)
      RATE_SEC:  return div_w - 1;
      RATE_DIV8: return 3;
      RATE_DIV4: return 2;
      default:   return 0;
    endcase
  endfunction

endpackage

// File: rtl/sqw_ctrl_reg.sv
module sqw_ctrl_reg
  import sqw_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [7:0]  wdata_i,
  output ctrl_t       ctrl_o,
  output logic [7:0]  rdata_o
);

  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '{lvl: 1'b0, en: 1'b0, rate: RATE_REF};
    end else if (wr_i) begin
      ctrl_q <= '{lvl: wdata_i[7], en: wdata_i[4], rate: rate_e'(wdata_i[1:0])};
    end
  end

  assign ctrl_o  = ctrl_q;
  assign rdata_o = {ctrl_q.lvl, 2'b00, ctrl_q.en, 2'b00, ctrl_q.rate};

endmodule

// File: rtl/sqw_divider.sv
module sqw_divider #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [DIV_W-1:0] cnt_o,
  output logic             sec_tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic             sec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sec_q <= 1'b0;
    end else begin
      if (tick_i) cnt_q <= cnt_q + DIV_W'(1);
      // top bit falls on this tick
      sec_q <= tick_i & (&cnt_q);
    end
  end

  assign cnt_o      = cnt_q;
  assign sec_tick_o = sec_q;

endmodule

// File: rtl/sqw_out_stage.sv
module sqw_out_stage
  import sqw_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  ctrl_t            ctrl_i,
  input  logic [DIV_W-1:0] cnt_i,
  output logic             sqw_o,
  output logic             locked_o
);

  localparam int unsigned IDX_W = $clog2(DIV_W);

  logic [IDX_W-1:0] idx;
  logic [DIV_W-1:0] low_mask, cnt_sh;
  logic [DIV_W:0]   half_ticks;
  logic             toggle, tap_next, long_enough, following;

  logic             sqw_q, sqw_d;
  logic             act_en_q, act_en_d;
  rate_e            act_rate_q, act_rate_d;
  logic [DIV_W-1:0] dwell_q, dwell_d;

  assign idx         = IDX_W'(tap_idx(ctrl_i.rate, DIV_W));
  assign low_mask    = (DIV_W'(1) << idx) - DIV_W'(1);
  assign cnt_sh      = cnt_i >> idx;
  assign toggle      = tick_i & (&(cnt_i | ~low_mask));
  assign tap_next    = cnt_sh[0] ^ toggle;
  assign half_ticks  = (DIV_W + 1)'(1) << idx;
  assign long_enough = ({1'b0, dwell_q} + (DIV_W + 1)'(1)) >= half_ticks;
  assign following   = ctrl_i.en & act_en_q & (act_rate_q == ctrl_i.rate);

  always_comb begin
    sqw_d      = sqw_q;
    act_en_d   = act_en_q;
    act_rate_d = act_rate_q;
    if (!ctrl_i.en) begin
      sqw_d    = ctrl_i.lvl;
      act_en_d = 1'b0;
    end else if (following) begin
      sqw_d = tap_next;
    end else if (toggle && (tap_next == sqw_q || long_enough)) begin
      // switch only where no short segment can result
      sqw_d      = tap_next;
      act_en_d   = 1'b1;
      act_rate_d = ctrl_i.rate;
    end else begin
      act_en_d = 1'b0;
    end
  end

  always_comb begin
    if (sqw_d != sqw_q)                 dwell_d = '0;
    else if (tick_i && !(&dwell_q))     dwell_d = dwell_q + DIV_W'(1);
    else                                dwell_d = dwell_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sqw_q      <= 1'b0;
      act_en_q   <= 1'b0;
      act_rate_q <= RATE_REF;
      dwell_q    <= '0;
    end else begin
      sqw_q      <= sqw_d;
      act_en_q   <= act_en_d;
      act_rate_q <= act_rate_d;
      dwell_q    <= dwell_d;
    end
  end

  assign sqw_o    = sqw_q;
  assign locked_o = following;

endmodule

// File: rtl/sqw_gen.sv
module sqw_gen
  import sqw_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       ctrl_wr_i,
  input  logic [7:0] ctrl_wdata_i,
  output logic [7:0] ctrl_rdata_o,
  output logic       sqw_o,
  output logic       sec_tick_o
);

  ctrl_t            ctrl;
  logic [DIV_W-1:0] cnt;
  logic             locked;
  logic             lock_1hz;

  if (DIV_W < 5) begin : g_div_too_short
    $error("DIV_W must leave the slow tap above bit 3");
  end

  sqw_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ctrl_wr_i),
    .wdata_i (ctrl_wdata_i),
    .ctrl_o  (ctrl),
    .rdata_o (ctrl_rdata_o)
  );

  sqw_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .cnt_o      (cnt),
    .sec_tick_o (sec_tick_o)
  );

  sqw_out_stage #(.DIV_W(DIV_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .ctrl_i   (ctrl),
    .cnt_i    (cnt),
    .sqw_o    (sqw_o),
    .locked_o (locked)
  );

  assign lock_1hz = locked & (ctrl.rate == RATE_SEC);

endmodule

// File: rtl/sqw_gen_chk.sv
module sqw_gen_chk
  import sqw_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       ctrl_wr_i,
  input logic [7:0] ctrl_wdata_i,
  input logic [7:0] ctrl_rdata_o,
  input logic       sqw_o,
  input logic       sec_tick_o,
  input logic       lock_1hz_i
);

  logic           prev_q;
  logic [DIV_W:0] seg_q;

  function automatic logic [DIV_W:0] half_of(logic [1:0] rs);
    return (DIV_W + 1)'(1) << tap_idx(rate_e'(rs), DIV_W);
  endfunction

  // ticks in the output segment that ended at the last seen change
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      seg_q  <= '0;
    end else begin
      prev_q <= sqw_o;
      if (sqw_o != prev_q)                seg_q <= {{DIV_W{1'b0}}, tick_i};
      else if (tick_i && !(&seg_q))       seg_q <= seg_q + (DIV_W + 1)'(1);
    end
  end

  p_readback_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> ctrl_rdata_o == ($past(ctrl_wdata_i) & 8'h93));

  p_static_level_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_rdata_o[4] |=> sqw_o == $past(ctrl_rdata_o[7]));

  p_no_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && ctrl_rdata_o[4]) |=> ($stable(sqw_o) && !sec_tick_o));

  p_fall_has_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(lock_1hz_i) && $fell(sqw_o)) |-> sec_tick_o);

  p_strobe_on_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(lock_1hz_i) && sec_tick_o) |-> $fell(sqw_o));

  p_min_segment_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sqw_o != prev_q) && $past(ctrl_rdata_o[4])) |-> seg_q >= half_of($past(ctrl_rdata_o[1:0])));

endmodule

bind sqw_gen sqw_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .ctrl_wr_i    (ctrl_wr_i),
  .ctrl_wdata_i (ctrl_wdata_i),
  .ctrl_rdata_o (ctrl_rdata_o),
  .sqw_o        (sqw_o),
  .sec_tick_o   (sec_tick_o),
  .lock_1hz_i   (lock_1hz)
);

// File: tb/sim_sqw_gen.sv
module sim_sqw_gen;

  localparam int unsigned DIV_W = 10;
  localparam int SLOW_HALF = 1 << (DIV_W - 1);
  localparam int SEC_PER   = 1 << DIV_W;

  typedef struct packed {
    logic [7:0]  wr;
    logic [7:0]  rd;
    logic [15:0] half;   // 0: static level expected
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'h00, 8'h00, 16'd0},
    '{8'h80, 8'h80, 16'd0},
    '{8'hFF, 8'h93, 16'd1},
    '{8'h10, 8'h10, 16'(SLOW_HALF)},
    '{8'h12, 8'h12, 16'd4},
    '{8'h91, 8'h91, 16'd8},
    '{8'h6C, 8'h00, 16'd0},
    '{8'hEF, 8'h83, 16'd0}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b1;
  logic       ctrl_wr_i = 1'b0;
  logic [7:0] ctrl_wdata_i = 8'h00;
  logic [7:0] ctrl_rdata_o;
  logic       sqw_o, sec_tick_o;

  int tests = 0, fails = 0;
  int cyc = 0, last_edge = 0, last_seg = 0;
  logic sqw_prev = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sqw_gen #(.DIV_W(DIV_W)) u0 (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .ctrl_wr_i    (ctrl_wr_i),
    .ctrl_wdata_i (ctrl_wdata_i),
    .ctrl_rdata_o (ctrl_rdata_o),
    .sqw_o        (sqw_o),
    .sec_tick_o   (sec_tick_o)
  );

  // segment length monitor, in cycles between output changes
  always @(negedge clk) begin
    cyc <= cyc + 1;
    sqw_prev <= sqw_o;
    if (sqw_o !== sqw_prev) begin
      last_seg  <= cyc - last_edge;
      last_edge <= cyc;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_ge(input string req, input int act, input int lim);
    tests++;
    if (act < lim) begin
      fails++;
      $display("FAIL %s: actual %0d expected at least %0d", req, act, lim);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    ctrl_wr_i = 1'b1;
    ctrl_wdata_i = d;
    @(negedge clk);
    ctrl_wr_i = 1'b0;
  endtask

  task automatic wait_change(input string req);
    logic s;
    int n;
    s = sqw_o;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sqw_o == s && n < 4000);
    if (n >= 4000) chk(req, 0, 1);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int bad, falls, n;
    logic s;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", int'(ctrl_rdata_o), 8'h03);
    chk("R1 sqw in reset", int'(sqw_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 rdata after reset", int'(ctrl_rdata_o), 8'h03);
    chk("R1 sqw after reset", int'(sqw_o), 0);
    chk("R1 strobe after reset", int'(sec_tick_o), 0);

    // R2 R3 R4 vector walk
    foreach (VECS[i]) begin
      wr(VECS[i].wr);
      chk("R2 readback", int'(ctrl_rdata_o), int'(VECS[i].rd));
      if (VECS[i].half == 0) begin
        @(negedge clk);
        chk("R3 static level", int'(sqw_o), int'(VECS[i].rd[7]));
        bad = 0;
        repeat (20) begin
          @(negedge clk);
          if (sqw_o !== VECS[i].rd[7]) bad++;
        end
        chk("R3 static hold", bad, 0);
      end else begin
        repeat (3) wait_change("R4 settle");
        wait_change("R4 measure");
        chk("R4 half period", last_seg, int'(VECS[i].half));
      end
    end

    // R5 divider frozen without ticks
    wr(8'h13);
    repeat (10) @(negedge clk);
    tick_i = 1'b0;
    s = sqw_o;
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (sqw_o !== s || sec_tick_o) bad++;
    end
    tick_i = 1'b1;
    chk("R5 hold without tick", bad, 0);

    // R6 strobe period and width
    n = 0;
    while (!sec_tick_o && n < 3000) begin @(negedge clk); n++; end
    chk("R6 strobe seen", int'(sec_tick_o), 1);
    n = 0;
    do begin @(negedge clk); n++; end while (!sec_tick_o && n < 3000);
    chk("R6 strobe period", n, SEC_PER);
    @(negedge clk);
    chk("R6 strobe width", int'(sec_tick_o), 0);

    // R7 strobe coincides with slow falling edge
    wr(8'h10);
    repeat (3) wait_change("R7 settle");
    bad = 0;
    falls = 0;
    s = sqw_o;
    repeat (2600) begin
      @(negedge clk);
      if ((s && !sqw_o) != sec_tick_o) bad++;
      if (s && !sqw_o) falls++;
      s = sqw_o;
    end
    chk("R7 strobe vs fall mismatches", bad, 0);
    chk_ge("R7 falls observed", falls, 2);

    // R8 fast to slow right after an edge
    wr(8'h13);
    repeat (3) wait_change("R8 settle");
    wait_change("R8 sync");
    wr(8'h10);
    wait_change("R8 switch");
    chk_ge("R8 segment across switch", last_seg, SLOW_HALF);
    wait_change("R8 follow");
    chk("R8 slow after switch", last_seg, SLOW_HALF);

    // R8 rate flipped away and back before the switch
    wr(8'h11);
    repeat (3) wait_change("R8 settle b");
    wait_change("R8 sync b");
    wr(8'h12);
    wr(8'h11);
    wait_change("R8 switch b");
    chk_ge("R8 segment after reselect", last_seg, 8);
    wait_change("R8 follow b");
    chk("R8 rate after reselect", last_seg, 8);

    finish_run();
  end

endmodule